// File: doc/BRIEF.md
# Enclave Page-Add Fault Checker

This block decides whether a request to add a fresh, zeroed page to an enclave that has already been initialized may go ahead. If it may not, the block reports which fault must be raised. The environment presents the addresses of the request and the results of its own lookups. These lookups are region hits, page-map entry state for the destination page and the enclave control page, lock state, the control page's base, size and initialized flag, and the shadow-stack capability and enable bits. A one-cycle `start` pulse latches all of these inputs.

The block then evaluates one check per clock, in a fixed priority order, and stops at the first check that fails. It returns a one-cycle `done` pulse with a 2-bit outcome: proceed, general-protection fault, page fault, or virtualization exit. The pulse also carries a 64-bit fault address and, for an exit, a qualification word. If no attribute block is supplied, the block substitutes default attributes. Shadow-stack page types get extra rules. The block never touches memory or the page map itself.

Top module: `enclave_page_add_checker`

## Requirements
- R1: A `start` seen while idle latches every input and raises `busy`. The latched values decide the result; input changes and further `start` pulses while busy are ignored. Checks run at indices 0 to 12, one per cycle. `done` pulses for exactly one cycle, i+1 cycles after the capturing edge when check i is the first to fail, or 13 cycles after it when all pass. Outcome code (0 proceed, 1 general-protection, 2 page fault, 3 virtualization exit), `fault_addr` and `exit_info` hold until the next completion. All are zero after reset.
- R2: Check 0 gives a general-protection fault when the parameter-block address has any of bits [4:0] set or the destination address has any of bits [11:0] set. A general-protection fault always reports `fault_addr` 0 and `exit_info` 0.
- R3: Check 1 gives a page fault with `fault_addr` equal to the destination address when `dest_in_region` is 0.
- R4: Check 2 gives a general-protection fault in any of these cases: the attribute-block address is nonzero with any of bits [5:0] set; the control-page address or the target linear address has any of bits [11:0] set; the source-page field is nonzero.
- R5: Check 3 gives a page fault on the control-page address when `ctl_in_region` is 0. It therefore wins over a locked destination.
- R6: Check 4 handles a locked destination. If both `guest_mode` and `virt_ext_en` are 1, it gives outcome 3 with `fault_addr` set to the destination and `exit_info` 32'h0000_0001 (error 0 in bits [31:16], conflict code 1 in bits [15:0]). Otherwise it gives a general-protection fault.
- R7: Check 5 gives a page fault on the destination when `dest_valid` is 1.
- R8: A zero attribute-block address selects type regular (1) with read and write set and execute clear. The attribute inputs then have no effect. With a nonzero address, check 6 gives a general-protection fault in any of these cases: a reserved bit is set, `ss_supported` is 0, the type is neither shadow-stack-first (5) nor shadow-stack-rest (6), read is 0, write is 0, or execute is 1.
- R9: Check 7 gives a general-protection fault when the effective type is 5 or 6 and `ss_enabled` is 0.
- R10: A locked control page gives a general-protection fault at check 8. A control page that is invalid or whose type is not 0 gives a page fault on the control-page address at check 9. An enclave that is not initialized gives a general-protection fault at check 10.
- R11: Check 11 gives a general-protection fault unless base ≤ linear address < base+size. The sum is evaluated without overflow.
- R12: Check 12 gives a general-protection fault when the effective type is 5 or 6 and the linear address equals the base or base+size-0x1000.
- R13: Only the first failing check in index order is reported. A request that passes every check reports outcome 0 with `fault_addr` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an evaluation (ignored while busy) |
| pblk_addr | input | 64 | Parameter-block address |
| dest_addr | input | 64 | Destination page address |
| attr_addr | input | 64 | Attribute-block address, zero when absent |
| attr_rsvd | input | 48 | Reserved bits of the attribute block |
| attr_type | input | 8 | Requested page type |
| attr_r | input | 1 | Requested read permission |
| attr_w | input | 1 | Requested write permission |
| attr_x | input | 1 | Requested execute permission |
| lin_addr | input | 64 | Target linear address |
| src_page | input | 64 | Source-page field |
| ctl_addr | input | 64 | Enclave control-page address |
| dest_in_region | input | 1 | Destination lies in the protected region |
| ctl_in_region | input | 1 | Control page lies in the protected region |
| dest_locked | input | 1 | Destination held by another thread |
| dest_valid | input | 1 | Destination page-map entry already valid |
| ctl_locked | input | 1 | Control page held by another thread |
| ctl_valid | input | 1 | Control page-map entry valid |
| ctl_type | input | 8 | Page type of the control page entry |
| ctl_inited | input | 1 | Enclave has been initialized |
| ctl_base | input | 64 | Enclave range base |
| ctl_size | input | 64 | Enclave range size |
| ss_supported | input | 1 | Shadow-stack pages reported as supported |
| ss_enabled | input | 1 | Control-register shadow-stack enable |
| guest_mode | input | 1 | Running as a virtualized guest |
| virt_ext_en | input | 1 | Page-conflict exits enabled |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| outcome | output | 2 | 0 proceed, 1 general-protection, 2 page fault, 3 exit |
| fault_addr | output | 64 | Faulting address for page fault or exit |
| exit_info | output | 32 | Exit qualification: error [31:16], code [15:0] |

## Verification
Each result is due i+1 cycles after the edge that captures `start`, where i is the index of the first failing check; a fully passing request completes after 13 cycles. The bench drives `start` on a falling edge and counts falling edges until `done` is seen, then compares that count with the expected latency. It samples outcome, address and qualification in the same half-cycle. Priority is tested by making two checks fail together and confirming that the lower index, with its earlier latency, is the one reported.

// File: rtl/enclave_page_add_checker.sv
module enclave_page_add_checker #(
  parameter int AW = 64,
  parameter int TW = 8,
  parameter int RSVW = 48,
  parameter int PAGE_SHIFT = 12,
  parameter int PB_SHIFT = 5,
  parameter int AB_SHIFT = 6,
  parameter logic [TW-1:0] T_CTL = 0,
  parameter logic [TW-1:0] T_REG = 1,
  parameter logic [TW-1:0] T_SSF = 5,
  parameter logic [TW-1:0] T_SSR = 6,
  parameter logic [15:0] CONFLICT_CODE = 16'h0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   pblk_addr,
  input  logic [AW-1:0]   dest_addr,
  input  logic [AW-1:0]   attr_addr,
  input  logic [RSVW-1:0] attr_rsvd,
  input  logic [TW-1:0]   attr_type,
  input  logic            attr_r,
  input  logic            attr_w,
  input  logic            attr_x,
  input  logic [AW-1:0]   lin_addr,
  input  logic [AW-1:0]   src_page,
  input  logic [AW-1:0]   ctl_addr,
  input  logic            dest_in_region,
  input  logic            ctl_in_region,
  input  logic            dest_locked,
  input  logic            dest_valid,
  input  logic            ctl_locked,
  input  logic            ctl_valid,
  input  logic [TW-1:0]   ctl_type,
  input  logic            ctl_inited,
  input  logic [AW-1:0]   ctl_base,
  input  logic [AW-1:0]   ctl_size,
  input  logic            ss_supported,
  input  logic            ss_enabled,
  input  logic            guest_mode,
  input  logic            virt_ext_en,
  output logic            busy,
  output logic            done,
  output logic [1:0]      outcome,
  output logic [AW-1:0]   fault_addr,
  output logic [31:0]     exit_info
);

  localparam int NCHK = 13;
  localparam int SW = $clog2(NCHK + 1);
  localparam logic [SW-1:0] LAST = SW'(NCHK - 1);
  localparam logic [AW:0] PAGE = (AW+1)'(1) << PAGE_SHIFT;
  localparam logic [1:0] OC_OK = 2'd0, OC_GP = 2'd1, OC_PF = 2'd2, OC_VX = 2'd3;

  logic [AW-1:0]   q_pblk, q_dest, q_attr, q_lin, q_src, q_ctl, q_base, q_size;
  logic [RSVW-1:0] q_rsvd;
  logic [TW-1:0]   q_atype, q_ctype;
  logic q_r, q_w, q_x, q_dreg, q_creg, q_dlock, q_dvalid, q_clock, q_cvalid;
  logic q_init, q_ssup, q_ssen, q_guest, q_virt;
  logic [SW-1:0] step;

  logic          attr_given, eff_ss, attr_bad, out_low, out_high, on_edge;
  logic [TW-1:0] eff_type;
  logic [AW:0]   lim;
  logic          fail;
  logic [1:0]    fcode;
  logic [AW-1:0] faddr;

  assign attr_given = |q_attr;
  assign eff_type   = attr_given ? q_atype : T_REG;
  assign eff_ss     = (eff_type == T_SSF) || (eff_type == T_SSR);
  assign attr_bad   = attr_given &&
                      ((|q_rsvd) || !q_ssup || !eff_ss || !q_r || !q_w || q_x);
  assign lim        = {1'b0, q_base} + {1'b0, q_size};
  assign out_low    = q_lin < q_base;
  assign out_high   = {1'b0, q_lin} >= lim;
  assign on_edge    = (q_lin == q_base) || ({1'b0, q_lin} == lim - PAGE);

  always_comb begin
    fail  = 1'b0;
    fcode = OC_GP;
    faddr = '0;
    case (step)
      4'd0: fail = (|q_pblk[PB_SHIFT-1:0]) || (|q_dest[PAGE_SHIFT-1:0]);
      4'd1: begin fail = !q_dreg; fcode = OC_PF; faddr = q_dest; end
      4'd2: fail = (attr_given && (|q_attr[AB_SHIFT-1:0])) ||
                   (|q_ctl[PAGE_SHIFT-1:0]) || (|q_lin[PAGE_SHIFT-1:0]) ||
                   (|q_src);
      4'd3: begin fail = !q_creg; fcode = OC_PF; faddr = q_ctl; end
      4'd4: begin
        fail = q_dlock;
        if (q_guest && q_virt) begin fcode = OC_VX; faddr = q_dest; end
      end
      4'd5: begin fail = q_dvalid; fcode = OC_PF; faddr = q_dest; end
      4'd6: fail = attr_bad;
      4'd7: fail = eff_ss && !q_ssen;
      4'd8: fail = q_clock;
      4'd9: begin
        fail = !q_cvalid || (q_ctype != T_CTL); fcode = OC_PF; faddr = q_ctl;
      end
      4'd10: fail = !q_init;
      4'd11: fail = out_low || out_high;
      4'd12: fail = eff_ss && on_edge;
      default: fail = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; outcome <= OC_OK; fault_addr <= '0;
      exit_info <= '0; step <= '0;
      q_pblk <= '0; q_dest <= '0; q_attr <= '0; q_lin <= '0; q_src <= '0;
      q_ctl <= '0; q_base <= '0; q_size <= '0; q_rsvd <= '0;
      q_atype <= '0; q_ctype <= '0; q_r <= 1'b0; q_w <= 1'b0; q_x <= 1'b0;
      q_dreg <= 1'b0; q_creg <= 1'b0; q_dlock <= 1'b0; q_dvalid <= 1'b0;
      q_clock <= 1'b0; q_cvalid <= 1'b0; q_init <= 1'b0; q_ssup <= 1'b0;
      q_ssen <= 1'b0; q_guest <= 1'b0; q_virt <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; step <= '0;
          q_pblk <= pblk_addr; q_dest <= dest_addr; q_attr <= attr_addr;
          q_lin <= lin_addr; q_src <= src_page; q_ctl <= ctl_addr;
          q_base <= ctl_base; q_size <= ctl_size; q_rsvd <= attr_rsvd;
          q_atype <= attr_type; q_ctype <= ctl_type;
          q_r <= attr_r; q_w <= attr_w; q_x <= attr_x;
          q_dreg <= dest_in_region; q_creg <= ctl_in_region;
          q_dlock <= dest_locked; q_dvalid <= dest_valid;
          q_clock <= ctl_locked; q_cvalid <= ctl_valid; q_init <= ctl_inited;
          q_ssup <= ss_supported; q_ssen <= ss_enabled;
          q_guest <= guest_mode; q_virt <= virt_ext_en;
        end
      end else if (fail || step == LAST) begin
        busy       <= 1'b0;
        done       <= 1'b1;
        outcome    <= fail ? fcode : OC_OK;
        fault_addr <= fail ? faddr : '0;
        exit_info  <= (fail && fcode == OC_VX) ? {16'h0000, CONFLICT_CODE} : 32'h0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  assert_gp_no_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && outcome == OC_GP) |-> (fault_addr == '0 && exit_info == 32'h0));

  assert_pf_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && outcome == OC_PF) |-> (fault_addr == q_dest || fault_addr == q_ctl));

  assert_exit_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && outcome == OC_VX) |-> (q_guest && q_virt && q_dlock && fault_addr == q_dest));

  assert_ok_clean_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (done && outcome == OC_OK) |->
      (fault_addr == '0 && q_dreg && q_creg && !q_dvalid && !q_dlock && q_init));

endmodule

// File: tb/enclave_page_add_checker_bench.sv
module enclave_page_add_checker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] pblk_addr, dest_addr, attr_addr, lin_addr, src_page, ctl_addr, ctl_base, ctl_size;
  logic [47:0] attr_rsvd;
  logic [7:0]  attr_type, ctl_type;
  logic attr_r, attr_w, attr_x, dest_in_region, ctl_in_region, dest_locked, dest_valid;
  logic ctl_locked, ctl_valid, ctl_inited, ss_supported, ss_enabled, guest_mode, virt_ext_en;
  logic busy, done;
  logic [1:0]  outcome;
  logic [63:0] fault_addr;
  logic [31:0] exit_info;
  int checks = 0;
  int errors = 0;

  localparam logic [63:0] DEST = 64'h2000_0000, CTL = 64'h3000_0000, BASE = 64'h4000_0000;

  always #2 clk = ~clk;

  enclave_page_add_checker u_enclave_page_add_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .pblk_addr(pblk_addr), .dest_addr(dest_addr),
    .attr_addr(attr_addr), .attr_rsvd(attr_rsvd), .attr_type(attr_type), .attr_r(attr_r),
    .attr_w(attr_w), .attr_x(attr_x), .lin_addr(lin_addr), .src_page(src_page),
    .ctl_addr(ctl_addr), .dest_in_region(dest_in_region), .ctl_in_region(ctl_in_region),
    .dest_locked(dest_locked), .dest_valid(dest_valid), .ctl_locked(ctl_locked),
    .ctl_valid(ctl_valid), .ctl_type(ctl_type), .ctl_inited(ctl_inited), .ctl_base(ctl_base),
    .ctl_size(ctl_size), .ss_supported(ss_supported), .ss_enabled(ss_enabled),
    .guest_mode(guest_mode), .virt_ext_en(virt_ext_en), .busy(busy), .done(done),
    .outcome(outcome), .fault_addr(fault_addr), .exit_info(exit_info));

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic set_good();
    pblk_addr = 64'h1000_0020; dest_addr = DEST; attr_addr = 64'h0;
    attr_rsvd = '0; attr_type = 8'd5; attr_r = 1'b1; attr_w = 1'b1; attr_x = 1'b0;
    lin_addr = BASE + 64'h5000; src_page = 64'h0; ctl_addr = CTL;
    dest_in_region = 1'b1; ctl_in_region = 1'b1; dest_locked = 1'b0; dest_valid = 1'b0;
    ctl_locked = 1'b0; ctl_valid = 1'b1; ctl_type = 8'd0; ctl_inited = 1'b1;
    ctl_base = BASE; ctl_size = 64'h1_0000; ss_supported = 1'b1; ss_enabled = 1'b1;
    guest_mode = 1'b0; virt_ext_en = 1'b0;
  endtask

  task automatic go(input string tag, input logic [1:0] eo, input logic [63:0] ea, input int elat);
    int n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(tag, "latency", 64'(n), 64'(elat));
    chk(tag, "outcome", 64'(outcome), 64'(eo));
    chk(tag, "fault_addr", fault_addr, ea);
    chk(tag, "exit_info", 64'(exit_info), (eo == 2'd3) ? 64'h1 : 64'h0);
    @(negedge clk);
    set_good();
  endtask

  task automatic t_reset();
    chk("R1", "busy at reset", 64'(busy), 64'h0);
    chk("R1", "done at reset", 64'(done), 64'h0);
    chk("R1", "outcome at reset", 64'(outcome), 64'h0);
    chk("R1", "fault_addr at reset", fault_addr, 64'h0);
  endtask

  task automatic t_defaults_R8();
    set_good(); go("R13 clean pass", 2'd0, 64'h0, 13);
    attr_type = 8'd3; attr_rsvd = 48'h1; attr_x = 1'b1; attr_r = 1'b0;
    go("R8 absent block ignores fields", 2'd0, 64'h0, 13);
    attr_addr = 64'h5000_0040; attr_type = 8'd6;
    go("R8 shadow-rest accepted", 2'd0, 64'h0, 13);
    attr_addr = 64'h5000_0040; attr_rsvd = 48'h8000; go("R8 reserved set", 2'd1, 64'h0, 7);
    attr_addr = 64'h5000_0040; attr_type = 8'd1; go("R8 regular type supplied", 2'd1, 64'h0, 7);
    attr_addr = 64'h5000_0040; attr_x = 1'b1; go("R8 execute set", 2'd1, 64'h0, 7);
    attr_addr = 64'h5000_0040; attr_w = 1'b0; go("R8 write clear", 2'd1, 64'h0, 7);
    attr_addr = 64'h5000_0040; ss_supported = 1'b0; go("R8 feature absent", 2'd1, 64'h0, 7);
  endtask

  task automatic t_align_R2_R4();
    dest_addr = DEST + 64'h800; go("R2 dest misaligned", 2'd1, 64'h0, 1);
    pblk_addr = 64'h1000_0010; go("R2 param block misaligned", 2'd1, 64'h0, 1);
    attr_addr = 64'h5000_0020; go("R4 attr block misaligned", 2'd1, 64'h0, 3);
    ctl_addr = CTL + 64'h40; go("R4 control misaligned", 2'd1, 64'h0, 3);
    lin_addr = BASE + 64'h5008; go("R4 linear misaligned", 2'd1, 64'h0, 3);
    src_page = 64'h1000; go("R4 source nonzero", 2'd1, 64'h0, 3);
  endtask

  task automatic t_region_R3_R5();
    dest_in_region = 1'b0; go("R3 dest outside", 2'd2, DEST, 2);
    ctl_in_region = 1'b0; dest_locked = 1'b1; go("R5 control outside beats lock", 2'd2, CTL, 4);
  endtask

  task automatic t_lock_R6_R7();
    dest_locked = 1'b1; guest_mode = 1'b1; virt_ext_en = 1'b1;
    go("R6 guest exit", 2'd3, DEST, 5);
    dest_locked = 1'b1; guest_mode = 1'b1; go("R6 guest without ext", 2'd1, 64'h0, 5);
    dest_locked = 1'b1; go("R6 host lock", 2'd1, 64'h0, 5);
    dest_valid = 1'b1; go("R7 dest already valid", 2'd2, DEST, 6);
  endtask

  task automatic t_ss_R9_R12();
    attr_addr = 64'h5000_0040; ss_enabled = 1'b0; go("R9 shadow without enable", 2'd1, 64'h0, 8);
    ss_enabled = 1'b0; go("R9 regular without enable", 2'd0, 64'h0, 13);
    attr_addr = 64'h5000_0040; lin_addr = BASE; go("R12 shadow at base", 2'd1, 64'h0, 13);
    attr_addr = 64'h5000_0040; lin_addr = BASE + 64'hF000; go("R12 shadow at last page", 2'd1, 64'h0, 13);
    attr_addr = 64'h5000_0040; lin_addr = BASE + 64'h1000; go("R12 shadow next to base", 2'd0, 64'h0, 13);
  endtask

  task automatic t_ctl_R10_R11();
    ctl_locked = 1'b1; go("R10 control locked", 2'd1, 64'h0, 9);
    ctl_type = 8'd1; go("R10 control wrong type", 2'd2, CTL, 10);
    ctl_valid = 1'b0; go("R10 control invalid", 2'd2, CTL, 10);
    ctl_inited = 1'b0; go("R10 not initialized", 2'd1, 64'h0, 11);
    lin_addr = BASE - 64'h1000; go("R11 below base", 2'd1, 64'h0, 12);
    lin_addr = BASE + 64'h1_0000; go("R11 at limit", 2'd1, 64'h0, 12);
    lin_addr = BASE + 64'hF000; go("R11 last page regular", 2'd0, 64'h0, 13);
    ctl_base = 64'hFFFF_FFFF_FFFF_0000; lin_addr = 64'hFFFF_FFFF_FFFF_F000;
    go("R11 top of space no overflow", 2'd0, 64'h0, 13);
  endtask

  task automatic t_busy_R1();
    int n;
    dest_valid = 1'b1;
    go("R1 setup prior result", 2'd2, DEST, 6);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "busy mid run", 64'(busy), 64'h1);
    chk("R1", "outcome held while busy", 64'(outcome), 64'h2);
    dest_valid = 1'b1; dest_addr = 64'h7000_0001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 4;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk("R1", "latency with ignored start", 64'(n), 64'd13);
    chk("R1", "ignored start outcome", 64'(outcome), 64'h0);
    @(negedge clk);
    chk("R1", "done one cycle", 64'(done), 64'h0);
    repeat (2) @(negedge clk);
    chk("R1", "busy stays low", 64'(busy), 64'h0);
    set_good();
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_good();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_defaults_R8();
    t_align_R2_R4();
    t_region_R3_R5();
    t_lock_R6_R7();
    t_ss_R9_R12();
    t_ctl_R10_R11();
    t_busy_R1();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule